// File: doc/BRIEF.md
# Folded-Key Round Word Generator

This block turns a 128-bit cipher key into a sequence of 44 round-key words of 32 bits each. It does not use the usual word recurrence with round constants. Before each word is formed, the current 16 working key bytes are reduced to a 32-bit fold: the four bytes of each row are XORed together. That fold is XORed into a running word. Every fourth word is also rotated by one byte and then passed through the standard AES forward substitution box. Each finished word then overwrites one row of the working key bytes, so the fold for the next word depends on every word produced before it.

A one-cycle load strobe captures the key, clears the running word and starts the sequence. One word is then produced per clock. Each word comes with its index and a valid flag, and done is raised together with the last word. A load that arrives while a sequence is running discards that sequence and starts again from the new key. The substitution table is built at elaboration as a constant, so it needs no memory initialisation.

Top module: `kexp_fold`

## Requirements
- R1: While `rst` is high at a clock edge, `valid_o` and `done_o` are low after that edge. With no load after reset, they stay low.
- R2: If `load_i` is high at clock edge n, `valid_o` is low after edge n. Word i (i = 0..43) is presented after edge n+1+i, with `valid_o` high on each of these 44 consecutive cycles and `idx_o` equal to i.
- R3: Key byte K(b) is `key_i[8b+7:8b]`. The working bytes start equal to K(0..15). Fold byte F(j) is the XOR of working bytes 4j, 4j+1, 4j+2 and 4j+3. The fold word is {F(3),F(2),F(1),F(0)}, so F(0) sits in bits 7:0. The fold is computed again from the working bytes for every word.
- R4: The running word starts at zero on load. For an index i with i%4 != 0, word i is the previous running word XOR the fold.
- R5: For i%4 == 0, the value T = previous running word XOR fold is rotated left by 8 bits, so that bits 31:24 move to bits 7:0. Each byte is then replaced through the AES forward S-box, with S(0x00)=0x63, S(0x01)=0x7c and S(0x53)=0xed. No round constant is applied. Word 0 of an all-zero key is therefore 0x63636363.
- R6: After word i, working bytes 4*(i%4) to 4*(i%4)+3 take the bytes of word i, with the least significant byte going to the lowest byte position. Word i also becomes the running word for index i+1.
- R7: `done_o` is high only on the cycle that presents word 43. On the cycle after it, `valid_o` and `done_o` are low unless a new load has begun.
- R8: A load during a sequence restarts it. `valid_o` drops after the load edge, and the new key's word 0 follows as in R2, computed with the running word cleared.
- R9: Reset during a sequence stops it. No further words are presented until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Captures `key_i` and starts a sequence |
| key_i | input | 128 | Cipher key; byte b is bits 8b+7:8b |
| word_o | output | 32 | Current round-key word |
| idx_o | output | 6 | Index 0..43 of `word_o` |
| valid_o | output | 1 | `word_o` and `idx_o` hold a word |
| done_o | output | 1 | High with word 43 |

## Verification
Each word depends on every earlier word through both the running value and the rewritten working bytes. A fault in the fold byte order, the rotate direction or the row chosen for rewriting therefore only shows up downstream, often many words later. The bench compares all 44 words for a set of keys chosen to stress these paths: all-zero, all-ones, single-byte, ascending-byte and mixed. The expected values come from an arithmetic model that computes the substitution by field inversion. The hardest cases to reach are a restart in the middle of a sequence, which must not leak the old running word, and a reset in the middle of a sequence. The bench reaches both by pulsing load or reset after a chosen number of words.

// File: rtl/kexp_fold.sv
module kexp_fold (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [127:0] key_i,
  output logic [31:0]  word_o,
  output logic [5:0]   idx_o,
  output logic         valid_o,
  output logic         done_o
);
  localparam int NWORDS = 44;
  localparam logic [5:0] LAST = 6'(NWORDS - 1);

  typedef logic [7:0] sbox_t [256];

  function automatic sbox_t build_sbox();
    sbox_t t;
    logic [7:0] p, q, x;
    p = 8'h01;
    q = 8'h01;
    for (int n = 0; n < 255; n++) begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b0};
      q = q ^ {q[3:0], 4'b0};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
      t[p] = x ^ 8'h63;
    end
    t[0] = 8'h63;
    return t;
  endfunction

  localparam sbox_t SBOX = build_sbox();

  logic [127:0] wk;
  logic [31:0]  tmp;
  logic [5:0]   cnt;
  logic         run;
  logic [31:0]  fold, mixed, rot, nxt;

  for (genvar j = 0; j < 4; j++) begin : g_row
    assign fold[8*j +: 8] = wk[32*j +: 8] ^ wk[32*j+8 +: 8] ^ wk[32*j+16 +: 8] ^ wk[32*j+24 +: 8];
    assign nxt[8*j +: 8]  = (cnt[1:0] == 2'd0) ? SBOX[rot[8*j +: 8]] : mixed[8*j +: 8];
  end

  assign mixed = tmp ^ fold;
  assign rot   = {mixed[23:0], mixed[31:24]};

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      valid_o <= 1'b0;
      done_o  <= 1'b0;
    end else if (load_i) begin
      wk      <= key_i;
      tmp     <= '0;
      cnt     <= '0;
      run     <= 1'b1;
      valid_o <= 1'b0;
      done_o  <= 1'b0;
    end else if (run) begin
      word_o  <= nxt;
      idx_o   <= cnt;
      valid_o <= 1'b1;
      done_o  <= (cnt == LAST);
      tmp     <= nxt;
      wk[32*cnt[1:0] +: 32] <= nxt;
      cnt     <= cnt + 6'd1;
      run     <= (cnt != LAST);
    end else begin
      valid_o <= 1'b0;
      done_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/kexp_fold_chk.sv
module kexp_fold_chk (
  input logic        clk,
  input logic        rst,
  input logic        load_i,
  input logic [5:0]  idx_o,
  input logic        valid_o,
  input logic        done_o
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!valid_o && !done_o)); // R1
  AST_LOAD_DROPS_VALID: assert property (@(posedge clk) disable iff (rst) load_i |=> !valid_o); // R8
  AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (rst) done_o |-> (valid_o && idx_o == 6'd43)); // R7
  AST_LAST_HAS_DONE: assert property (@(posedge clk) disable iff (rst) (valid_o && idx_o == 6'd43) |-> done_o); // R7
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !done_o && !load_i) |=> (valid_o && idx_o == $past(idx_o) + 6'd1)); // R2
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (rst) (done_o && !load_i) |=> !valid_o); // R7
  AST_FIRST_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_o) |-> (idx_o == 6'd0 && $past(load_i, 2))); // R2
endmodule

bind kexp_fold kexp_fold_chk u_chk (
  .clk(clk), .rst(rst), .load_i(load_i),
  .idx_o(idx_o), .valid_o(valid_o), .done_o(done_o)
);

// File: tb/kexp_fold_bench.sv
module kexp_fold_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_i = 1'b0;
  logic [127:0] key_i = '0;
  logic [31:0] word_o;
  logic [5:0] idx_o;
  logic valid_o, done_o;
  int tests = 0, fails = 0;
  logic [31:0] exp_w [44];

  always #2.5 clk = ~clk;

  kexp_fold u_kexp_fold (.clk(clk), .rst(rst), .load_i(load_i), .key_i(key_i),
    .word_o(word_o), .idx_o(idx_o), .valid_o(valid_o), .done_o(done_o));

  function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
    logic [7:0] r = 8'h00;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) r = r ^ a;
      a = {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    end
    return r;
  endfunction

  function automatic logic [7:0] sb(logic [7:0] x);
    logic [7:0] y = 8'h01;
    logic [7:0] z;
    for (int k = 0; k < 254; k++) y = gmul(y, x);
    if (x == 8'h00) y = 8'h00;
    for (int k = 0; k < 8; k++)
      z[k] = y[k] ^ y[(k+4)%8] ^ y[(k+5)%8] ^ y[(k+6)%8] ^ y[(k+7)%8];
    return z ^ 8'h63;
  endfunction

  task automatic model(input logic [127:0] key);
    logic [7:0] kb [16];
    logic [31:0] t = '0, f;
    for (int b = 0; b < 16; b++) kb[b] = key[8*b +: 8];
    for (int i = 0; i < 44; i++) begin
      for (int j = 0; j < 4; j++) f[8*j +: 8] = kb[4*j] ^ kb[4*j+1] ^ kb[4*j+2] ^ kb[4*j+3];
      t = t ^ f;
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sb(t[31:24]), sb(t[23:16]), sb(t[15:8]), sb(t[7:0])};
      end
      exp_w[i] = t;
      for (int k = 0; k < 4; k++) kb[4*(i%4)+k] = t[8*k +: 8];
    end
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start(input logic [127:0] key);
    @(negedge clk); load_i = 1'b1; key_i = key;
    @(negedge clk); load_i = 1'b0;
    chk("R2 valid low after load", {62'd0, valid_o, done_o}, 64'd0);
    model(key);
  endtask

  task automatic run_all(input logic [127:0] key, input string tag);
    start(key);
    for (int i = 0; i < 44; i++) begin
      @(negedge clk);
      chk({tag, " R3 R4 R5 R6 word"}, {32'd0, word_o}, {32'd0, exp_w[i]});
      chk("R2 valid/idx", {56'd0, valid_o, 1'b0, idx_o}, {56'd0, 1'b1, 1'b0, 6'(i)});
      chk("R7 done", {63'd0, done_o}, {63'd0, i == 43});
    end
    @(negedge clk);
    chk("R7 quiet after done", {62'd0, valid_o, done_o}, 64'd0);
  endtask

  initial begin
    logic [127:0] asc;
    for (int b = 0; b < 16; b++) asc[8*b +: 8] = 8'(b);
    chk("R5 sbox anchor 00", {56'd0, sb(8'h00)}, 64'h63);
    chk("R5 sbox anchor 53", {56'd0, sb(8'h53)}, 64'hed);
    repeat (3) @(negedge clk);
    chk("R1 reset idle", {62'd0, valid_o, done_o}, 64'd0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 idle without load", {62'd0, valid_o, done_o}, 64'd0);
    model('0);
    chk("R5 zero key word0", {32'd0, exp_w[0]}, 64'h63636363);
    run_all('0, "zero");
    run_all({128{1'b1}}, "ones");
    run_all(128'h1, "byte0");
    run_all(128'h80 << 120, "byte15");
    run_all(asc, "asc");
    run_all(128'hbdf298de5e264ad1f5dec94aadf25b28, "mix");
    // R8: restart mid-run
    start(asc);
    repeat (7) @(negedge clk);
    run_all(128'hbdf298de5e264ad1f5dec94aadf25b28, "R8 restart");
    // R9: reset mid-run
    start(asc);
    repeat (9) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int c = 0; c < 50; c++) begin
      @(negedge clk);
      chk("R9 stopped after reset", {62'd0, valid_o, done_o}, 64'd0);
    end
    run_all(asc, "R9 after reset");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule